// File: doc/BRIEF.md
# Multiplexed-Address DRAM Array Front End

This block is the control side of an asynchronous dynamic memory, built around a small cell array held in registers. Three active-low strobes drive it: row strobe, column strobe and write enable. The row and the column address arrive one after the other on one shared address bus. When the row strobe falls, the chosen row is copied into a row buffer. Column strobe cycles then read or change words inside that buffer. When the row strobe rises, the whole buffer is written back into the array.

The strobes are sampled on a fast system clock, and edges are found by comparing each sample with the one before it, so the whole block is synchronous. A row can be opened with no column activity, which refreshes that row without driving data. If the column strobe is already low when the row strobe falls, the block refreshes the row named by an internal counter and ignores the address pins. The data output is split into a value and an output enable, and a pad outside the block builds the tri-state driver from the two.

Top module: `mdr_array_front`

## Requirements
- R1: After reset `dq_oe` is 0, every array word reads as 0, and the internal refresh row counter is 0.
- R2: In the clock where `ras_n` is first sampled low with `cas_n` high, the row address is taken from `addr[ROW_BITS-1:0]`. After that the pins may carry the column address.
- R3: With the row open, the clock that samples `cas_n` falling latches `addr[COL_BITS-1:0]` as the column. From the next clock, if `we_n` was high, `dq_oe` is 1 and `dq_out` shows the selected word.
- R4: Column c selects buffer bits `[c*DATA_W +: DATA_W]`. Each column holds its own word.
- R5: Every clock that samples `we_n` low while the column is active stores `din` into the selected word. `dq_oe` stays 0 from the following clock while that access lasts.
- R6: In the clock after `cas_n` is sampled high, `dq_oe` is 0.
- R7: The clock that samples `ras_n` rising writes the row buffer, including all changes, back into the row that was opened. Later accesses return the written data.
- R8: While `ras_n` stays low, any number of column cycles may read and write the open row. A read after a write in the same row cycle returns the new word.
- R9: A row cycle with no column activity keeps `dq_oe` at 0 and leaves the array contents unchanged.
- R10: If `cas_n` is low when `ras_n` is first sampled low, the row comes from the internal counter and the address pins are ignored. `dq_oe` stays 0 for the whole cycle, and no array contents change.
- R11: The refresh counter advances by one at the end of each counter-driven refresh cycle and wraps from `2**ROW_BITS-1` to 0. It holds its value at all other times.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System sampling clock |
| rst_n | input | 1 | Active-low synchronous reset |
| ras_n | input | 1 | Row strobe, active low |
| cas_n | input | 1 | Column strobe, active low |
| we_n | input | 1 | Write enable, active low |
| addr | input | ADDR_W | Shared row and column address |
| din | input | DATA_W | Write data |
| dq_out | output | DATA_W | Read data value |
| dq_oe | output | 1 | Output enable for the read data pad |

## Verification
The bench fills every word of a small array with a value computed from its row, its column and a seed, writing each row in page mode. It then reads everything back. This shows whether the column slicing is correct, whether writes land in the right row, and whether writeback happens. Passes of row-only refresh and counter-driven refresh, with the address pins held at misleading values, come before fresh readbacks. These separate a refresh that leaves data untouched from one that writes back to the wrong row. A read, a write and a second read inside one row cycle, plus a write enable that falls partway through a column cycle, tell buffer-forwarded data apart from stale array data.

// File: rtl/mdr_pkg.sv
package mdr_pkg;

  typedef enum logic [1:0] {
    CYC_IDLE    = 2'd0,
    CYC_ACCESS  = 2'd1,
    CYC_REFRESH = 2'd2
  } cyc_e;

  function automatic int unsigned wrap_next(int unsigned v, int unsigned lim);
    return (v + 1 >= lim) ? 0 : v + 1;
  endfunction

  function automatic int unsigned word_base(int unsigned col, int unsigned w);
    return col * w;
  endfunction

endpackage

// File: rtl/mdr_edge_det.sv
module mdr_edge_det (
  input  logic clk,
  input  logic rst_n,
  input  logic sig_n,
  output logic fall,
  output logic rise
);
  logic prev_q;

  always_ff @(posedge clk) begin
    if (!rst_n) prev_q <= 1'b1;
    else        prev_q <= sig_n;
  end

  assign fall = prev_q & ~sig_n;
  assign rise = ~prev_q & sig_n;
endmodule

// File: rtl/mdr_refresh_ctr.sv
module mdr_refresh_ctr #(
  parameter int ROW_BITS = 4
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                step,
  output logic [ROW_BITS-1:0] ref_row
);
  localparam int unsigned ROWS = 1 << ROW_BITS;
  logic [ROW_BITS-1:0] cnt_q;

  always_ff @(posedge clk) begin
    if (!rst_n) cnt_q <= '0;
    else if (step)
      cnt_q <= ROW_BITS'(mdr_pkg::wrap_next(32'(cnt_q), ROWS));
  end

  assign ref_row = cnt_q;
endmodule

// File: rtl/mdr_cell_array.sv
module mdr_cell_array #(
  parameter int ROW_BITS = 4,
  parameter int ROW_W    = 32
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic [ROW_BITS-1:0] rd_row,
  output logic [ROW_W-1:0]    rd_data,
  input  logic                wr_en,
  input  logic [ROW_BITS-1:0] wr_row,
  input  logic [ROW_W-1:0]    wr_data
);
  localparam int ROWS = 1 << ROW_BITS;
  logic [ROW_W-1:0] mem_q [ROWS];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < ROWS; i++) mem_q[i] <= '0;
    end else if (wr_en) begin
      mem_q[wr_row] <= wr_data;
    end
  end

  assign rd_data = mem_q[rd_row];
endmodule

// File: rtl/mdr_row_buffer.sv
module mdr_row_buffer #(
  parameter int COL_BITS = 4,
  parameter int DATA_W   = 2
) (
  input  logic                                 clk,
  input  logic                                 rst_n,
  input  logic                                 load,
  input  logic [(1<<COL_BITS)*DATA_W-1:0]      load_data,
  input  logic                                 wr_en,
  input  logic [COL_BITS-1:0]                  wr_col,
  input  logic [DATA_W-1:0]                    wr_data,
  input  logic [COL_BITS-1:0]                  rd_col,
  output logic [DATA_W-1:0]                    rd_data,
  output logic [(1<<COL_BITS)*DATA_W-1:0]      row_data
);
  localparam int COLS  = 1 << COL_BITS;
  localparam int ROW_W = COLS * DATA_W;

  logic [ROW_W-1:0] buf_q;
  logic [DATA_W-1:0] words [COLS];

  genvar g;
  generate
    for (g = 0; g < COLS; g++) begin : g_word
      assign words[g] = buf_q[g*DATA_W +: DATA_W];
    end
  endgenerate

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      buf_q <= '0;
    end else if (load) begin
      buf_q <= load_data;
    end else if (wr_en) begin
      buf_q[mdr_pkg::word_base(32'(wr_col), DATA_W) +: DATA_W] <= wr_data;
    end
  end

  assign rd_data  = words[rd_col];
  assign row_data = buf_q;
endmodule

// File: rtl/mdr_array_front.sv
module mdr_array_front #(
  parameter int ROW_BITS = 4,
  parameter int COL_BITS = 4,
  parameter int DATA_W   = 2,
  parameter int ADDR_W   = (ROW_BITS > COL_BITS) ? ROW_BITS : COL_BITS
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              ras_n,
  input  logic              cas_n,
  input  logic              we_n,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0] din,
  output logic [DATA_W-1:0] dq_out,
  output logic              dq_oe
);
  import mdr_pkg::*;

  localparam int COLS  = 1 << COL_BITS;
  localparam int ROW_W = COLS * DATA_W;

  // edge events
  logic ras_fall, ras_rise, cas_fall, cas_rise;

  mdr_edge_det u_ras_edge (.clk(clk), .rst_n(rst_n), .sig_n(ras_n),
                           .fall(ras_fall), .rise(ras_rise));
  mdr_edge_det u_cas_edge (.clk(clk), .rst_n(rst_n), .sig_n(cas_n),
                           .fall(cas_fall), .rise(cas_rise));

  // control state
  cyc_e                state_q;
  logic [ROW_BITS-1:0] row_q;
  logic [COL_BITS-1:0] col_q;
  logic                cas_active;
  logic                wr_mode;

  // named internal events
  logic                open_q, cbr_q;
  logic                row_start, use_cbr, wb_fire, col_start, cas_hold;
  logic                buf_wr;
  logic [COL_BITS-1:0] buf_wr_col;
  logic [ROW_BITS-1:0] row_sel, ref_row;
  logic [ROW_W-1:0]    arr_rd, buf_row;
  logic                cas_rise_seen;

  assign open_q    = (state_q != CYC_IDLE);
  assign cbr_q     = (state_q == CYC_REFRESH);
  assign row_start = ras_fall & ~open_q;
  assign use_cbr   = ~cas_n;
  assign row_sel   = use_cbr ? ref_row : addr[ROW_BITS-1:0];
  assign wb_fire   = ras_rise & open_q;
  assign col_start = cas_fall & open_q & ~cbr_q & ~ras_n;
  assign cas_hold  = cas_active & ~cas_n & ~ras_n;
  assign buf_wr    = (col_start | cas_hold) & ~we_n;
  assign buf_wr_col = col_start ? addr[COL_BITS-1:0] : col_q;
  assign cas_rise_seen = cas_rise;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state_q    <= CYC_IDLE;
      row_q      <= '0;
      col_q      <= '0;
      cas_active <= 1'b0;
      wr_mode    <= 1'b0;
    end else if (row_start) begin
      state_q    <= use_cbr ? CYC_REFRESH : CYC_ACCESS;
      row_q      <= row_sel;
      cas_active <= 1'b0;
      wr_mode    <= 1'b0;
    end else if (wb_fire) begin
      state_q    <= CYC_IDLE;
      cas_active <= 1'b0;
      wr_mode    <= 1'b0;
    end else if (open_q) begin
      if (col_start) begin
        cas_active <= 1'b1;
        col_q      <= addr[COL_BITS-1:0];
        wr_mode    <= ~we_n;
      end else if (cas_n || cas_rise_seen) begin
        cas_active <= 1'b0;
        wr_mode    <= 1'b0;
      end else if (cas_active && !we_n) begin
        wr_mode    <= 1'b1;
      end
    end
  end

  mdr_refresh_ctr #(.ROW_BITS(ROW_BITS)) u_ref (
    .clk(clk), .rst_n(rst_n), .step(wb_fire & cbr_q), .ref_row(ref_row)
  );

  mdr_cell_array #(.ROW_BITS(ROW_BITS), .ROW_W(ROW_W)) u_array (
    .clk(clk), .rst_n(rst_n),
    .rd_row(row_sel), .rd_data(arr_rd),
    .wr_en(wb_fire), .wr_row(row_q), .wr_data(buf_row)
  );

  mdr_row_buffer #(.COL_BITS(COL_BITS), .DATA_W(DATA_W)) u_buf (
    .clk(clk), .rst_n(rst_n),
    .load(row_start), .load_data(arr_rd),
    .wr_en(buf_wr), .wr_col(buf_wr_col), .wr_data(din),
    .rd_col(col_q), .rd_data(dq_out), .row_data(buf_row)
  );

  assign dq_oe = cas_active & ~wr_mode;
endmodule

// File: rtl/mdr_array_front_chk.sv
module mdr_array_front_chk #(
  parameter int ROW_BITS = 4
) (
  input logic                clk,
  input logic                rst_n,
  input logic                cas_n,
  input logic                dq_oe,
  input logic                open_q,
  input logic                cbr_q,
  input logic                wb_fire,
  input logic [ROW_BITS-1:0] ref_row
);
  localparam int unsigned ROWS = 1 << ROW_BITS;

  // R6
  p_cas_high_quiet_r6: assert property (@(posedge clk) disable iff (!rst_n)
    cas_n |=> !dq_oe);

  // R9
  p_closed_dark_r9: assert property (@(posedge clk) disable iff (!rst_n)
    !open_q |-> !dq_oe);

  // R10
  p_refresh_dark_r10: assert property (@(posedge clk) disable iff (!rst_n)
    cbr_q |-> !dq_oe);

  // R11
  p_ref_step_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (wb_fire && cbr_q) |=>
      (32'(ref_row) == mdr_pkg::wrap_next(32'($past(ref_row)), ROWS)));

  // R11
  p_ref_hold_r11: assert property (@(posedge clk) disable iff (!rst_n)
    !(wb_fire && cbr_q) |=> $stable(ref_row));
endmodule

bind mdr_array_front mdr_array_front_chk #(.ROW_BITS(ROW_BITS)) u_chk (
  .clk(clk), .rst_n(rst_n), .cas_n(cas_n), .dq_oe(dq_oe),
  .open_q(open_q), .cbr_q(cbr_q), .wb_fire(wb_fire), .ref_row(ref_row)
);

// File: tb/mdr_array_front_bench.sv
module mdr_array_front_bench;
  localparam int RB = 4, CB = 4, DW = 2, AW = 4;
  localparam int ROWS = 1 << RB, COLS = 1 << CB;

  logic clk = 1'b0, rst_n = 1'b0;
  logic ras_n = 1'b1, cas_n = 1'b1, we_n = 1'b1;
  logic [AW-1:0] addr = '0;
  logic [DW-1:0] din = '0;
  logic [DW-1:0] dq_out;
  logic dq_oe;

  int checks = 0, errors = 0;
  bit done = 0;
  logic [DW-1:0] model [ROWS][COLS];

  always #4 clk = ~clk;

  mdr_array_front #(.ROW_BITS(RB), .COL_BITS(CB), .DATA_W(DW)) u_mdr_array_front (
    .clk(clk), .rst_n(rst_n), .ras_n(ras_n), .cas_n(cas_n), .we_n(we_n),
    .addr(addr), .din(din), .dq_out(dq_out), .dq_oe(dq_oe));

  function automatic logic [DW-1:0] pat(int r, int c, int s);
    return DW'((r * 3 + c * 5 + s) % (1 << DW));
  endfunction

  task automatic check(bit ok, string tag, int act, int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic open_row(int r);
    addr = AW'(r); ras_n = 1'b0;
    @(negedge clk);
  endtask

  task automatic close_row();
    ras_n = 1'b1;
    @(negedge clk);
    @(negedge clk);
  endtask

  task automatic wr_col(int r, int c, logic [DW-1:0] d);
    addr = AW'(c); din = d; we_n = 1'b0; cas_n = 1'b0;
    @(negedge clk);
    check(dq_oe == 1'b0, "R5 oe low on write", int'(dq_oe), 0);
    cas_n = 1'b1; we_n = 1'b1;
    @(negedge clk);
    model[r][c] = d;
  endtask

  task automatic rd_col(int r, int c, string tag);
    addr = AW'(c); we_n = 1'b1; cas_n = 1'b0;
    @(negedge clk);
    check(dq_oe == 1'b1, {tag, " R3 oe"}, int'(dq_oe), 1);
    check(dq_out == model[r][c], {tag, " R4 data"}, int'(dq_out), int'(model[r][c]));
    cas_n = 1'b1;
    @(negedge clk);
    check(dq_oe == 1'b0, "R6 oe off after cas high", int'(dq_oe), 0);
  endtask

  task automatic write_all(int s);
    for (int r = 0; r < ROWS; r++) begin
      open_row(r);
      for (int c = 0; c < COLS; c++) wr_col(r, c, pat(r, c, s));
      close_row();
    end
  endtask

  task automatic read_all(string tag);
    for (int r = 0; r < ROWS; r++) begin
      open_row(r);
      for (int c = 0; c < COLS; c++) rd_col(r, c, tag);
      close_row();
    end
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    check(dq_oe == 1'b0, "R1 oe after reset", int'(dq_oe), 0);
    for (int r = 0; r < ROWS; r++)
      for (int c = 0; c < COLS; c++) model[r][c] = '0;
    read_all("R1 zero array");

    // R2 R7 R8: page-mode fill, then readback
    write_all(0);
    read_all("R7 readback seed0");

    // R9: row-only refresh of every row
    for (int r = 0; r < ROWS; r++) begin
      open_row(r);
      repeat (3) begin
        @(negedge clk);
        check(dq_oe == 1'b0, "R9 refresh dark", int'(dq_oe), 0);
      end
      close_row();
    end
    read_all("R9 after refresh");

    // R10: counter-driven refresh, pins misleading
    for (int k = 0; k < ROWS + 3; k++) begin
      cas_n = 1'b0;
      @(negedge clk);
      addr = AW'(k * 7 + 1); ras_n = 1'b0;
      repeat (3) begin
        @(negedge clk);
        check(dq_oe == 1'b0, "R10 cbr dark", int'(dq_oe), 0);
      end
      ras_n = 1'b1;
      @(negedge clk);
      cas_n = 1'b1;
      @(negedge clk);
      @(negedge clk);
    end
    read_all("R10 after cbr");

    // R8: read, write, read in one row cycle
    open_row(7);
    rd_col(7, 2, "R8 pre");
    wr_col(7, 2, ~model[7][2]);
    rd_col(7, 2, "R8 forwarded");
    wr_col(7, 9, ~model[7][9]);
    rd_col(7, 9, "R8 second col");
    // R5: write enable falling during a read
    addr = AW'(4); we_n = 1'b1; cas_n = 1'b0;
    @(negedge clk);
    check(dq_oe == 1'b1 && dq_out == model[7][4], "R5 late pre-read", int'(dq_out), int'(model[7][4]));
    din = ~model[7][4]; we_n = 1'b0;
    @(negedge clk);
    check(dq_oe == 1'b0, "R5 late write oe", int'(dq_oe), 0);
    model[7][4] = din;
    cas_n = 1'b1; we_n = 1'b1;
    @(negedge clk);
    rd_col(7, 4, "R5 late stored");
    close_row();
    read_all("R7 after page edits");

    write_all(1);
    read_all("R4 readback seed1");
    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog actual=0 expected=1");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule